// File: doc/BRIEF.md
# Vector tail/mask policy writeback merger

This block sits at the writeback end of a vector pipeline. It takes the freshly computed result for a whole destination register together with the register's previous contents. It then builds the word that is actually written back, deciding element by element what to keep. Each element falls into one of four classes, and the class sets the byte source:

| Class | Which elements | Bytes written |
|---|---|---|
| prestart | below the start index | old value |
| tail | at or above the vector length | old value or all ones |
| masked-off | masking on and mask bit clear | old value or all ones |
| active | all others | new value |

A two-bit policy value lives in a small type register inside the block. The upper bit marks tail elements as agnostic and the lower bit marks masked-off elements as agnostic. The code with only the lower bit set is reserved. It raises an illegal-type flag, and every merge then returns the old register unchanged. An element classed as agnostic is either filled with all ones or left undisturbed. A configuration input picks between the two, so both legal behaviours can be exercised. The policy register keeps both bits exactly as written, whatever the fill choice is.

The element width is selectable at 8, 16, 32 or 64 bits. The merged word is registered and appears one cycle after the request.

Top module: `vmerge_wb`

## Requirements
- R1: After reset, result_o is zero, result_valid_o is 0, policy_o reads 2'b00 and vill_o is 0.
- R2: A cycle with cfg_we_i high stores cfg_policy_i, and policy_o returns both bits unchanged from the next cycle on, for every one of the four codes.
- R3: While the stored policy is 2'b01, vill_o is 1 and every merge returns old_i unchanged. For any other code vill_o is 0.
- R4: An element with vstart_i <= index < vl_i is active when mask_en_i is 0 or its mask bit is 1, and it takes the corresponding bytes of new_i.
- R5: With policy bit 1 clear (tail undisturbed), elements with index >= vl_i keep their old_i bytes.
- R6: With policy bit 1 set (tail agnostic), tail elements become all ones when fill_ones_i is 1 and keep old_i when fill_ones_i is 0. With fill_ones_i at 0, every result byte equals the old or the new byte.
- R7: With mask_en_i at 1, an element below vl_i whose bit mask_i[index] is 0 is masked off. It keeps old_i when policy bit 0 is clear. When policy bit 0 is set it becomes all ones if fill_ones_i is 1 and keeps old_i if fill_ones_i is 0.
- R8: Elements with index below vstart_i keep their old_i bytes under every policy and fill setting. This takes priority over the tail and mask rules.
- R9: sew_i selects the element width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Element i occupies bytes i*w to i*w+w-1 of the register, where w is the width in bytes, and it is governed by mask_i[i].
- R10: A merge requested with valid_i high appears on result_o with result_valid_o high exactly one cycle later. result_valid_o is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write the policy register |
| cfg_policy_i | input | 2 | Policy value to store (bit 1 tail agnostic, bit 0 masked-off agnostic) |
| fill_ones_i | input | 1 | 1: agnostic elements are filled with ones; 0: they are left undisturbed |
| valid_i | input | 1 | Merge request |
| old_i | input | VLEN | Previous destination register contents |
| new_i | input | VLEN | Freshly computed result |
| mask_i | input | VLEN/8 | Mask bit per element index |
| mask_en_i | input | 1 | Masking enabled |
| vl_i | input | log2(VLEN/8)+1 | Vector length in elements |
| vstart_i | input | log2(VLEN/8)+1 | Start element index |
| sew_i | input | 2 | Element width code |
| policy_o | output | 2 | Stored policy read back |
| vill_o | output | 1 | Illegal type flag |
| result_valid_o | output | 1 | Merged word valid |
| result_o | output | VLEN | Merged register word |

## Verification
The bench builds the block with VLEN at its default of 128. That register holds 16 byte elements at the narrowest width and only two at the widest. With this size, vl_i can run from zero to the full register, and vl_i can also exceed the element count at wide widths. Start indices can reach the tail, so a prestart element and a tail element meet at the same index. Each width is run against the same mask and length, so the index-to-byte mapping is visible at every width.

// File: rtl/vmerge_pkg.sv
package vmerge_pkg;
  typedef enum logic [1:0] {
    ACT_OLD  = 2'd0,
    ACT_NEW  = 2'd1,
    ACT_ONES = 2'd2
  } act_e;

  localparam logic [1:0] POL_RSVD = 2'b01;
endpackage

// File: rtl/vmerge_policy_reg.sv
module vmerge_policy_reg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [1:0] pol_i,
  output logic [1:0] pol_o,
  output logic       vill_o,
  output logic       tail_agn_o,
  output logic       mask_agn_o
);
  import vmerge_pkg::*;

  logic [1:0] pol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pol_q <= 2'b00;
    else if (we_i) pol_q <= pol_i;
  end

  assign pol_o      = pol_q;
  assign vill_o     = (pol_q == POL_RSVD);
  assign tail_agn_o = pol_q[1];
  assign mask_agn_o = pol_q[0] & ~vill_o;
endmodule

// File: rtl/vmerge_byte_class.sv
module vmerge_byte_class #(
  parameter int NB       = 16,
  parameter int IDXW     = 4,
  parameter int CNTW     = 5,
  parameter int BYTE_IDX = 0
) (
  input  logic [1:0]       sew_i,
  input  logic [CNTW-1:0]  vl_i,
  input  logic [CNTW-1:0]  vstart_i,
  input  logic [NB-1:0]    mask_i,
  input  logic             mask_en_i,
  input  logic             tail_agn_i,
  input  logic             mask_agn_i,
  input  logic             fill_i,
  input  logic             vill_i,
  output vmerge_pkg::act_e act_o
);
  import vmerge_pkg::*;

  localparam logic [IDXW-1:0] BI = IDXW'(BYTE_IDX);

  logic [IDXW-1:0] idx;
  logic [CNTW-1:0] idx_ext;
  logic            pre, tail, moff;

  assign idx     = BI >> sew_i;
  assign idx_ext = {1'b0, idx};
  assign pre     = idx_ext < vstart_i;
  assign tail    = idx_ext >= vl_i;
  assign moff    = mask_en_i & ~mask_i[idx];

  // priority: illegal, prestart, tail, masked-off, active
  always_comb begin
    act_o = ACT_NEW;
    if (vill_i || pre)  act_o = ACT_OLD;
    else if (tail)      act_o = (tail_agn_i && fill_i) ? ACT_ONES : ACT_OLD;
    else if (moff)      act_o = (mask_agn_i && fill_i) ? ACT_ONES : ACT_OLD;
  end
endmodule

// File: rtl/vmerge_byte_mux.sv
module vmerge_byte_mux (
  input  vmerge_pkg::act_e act_i,
  input  logic [7:0]       old_i,
  input  logic [7:0]       new_i,
  output logic [7:0]       byte_o
);
  import vmerge_pkg::*;

  always_comb begin
    unique case (act_i)
      ACT_NEW:  byte_o = new_i;
      ACT_ONES: byte_o = 8'hFF;
      default:  byte_o = old_i;
    endcase
  end
endmodule

// File: rtl/vmerge_wb.sv
module vmerge_wb #(
  parameter int VLEN = 128,
  localparam int NB   = VLEN / 8,
  localparam int IDXW = $clog2(NB),
  localparam int CNTW = IDXW + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [1:0]      cfg_policy_i,
  input  logic            fill_ones_i,
  input  logic            valid_i,
  input  logic [VLEN-1:0] old_i,
  input  logic [VLEN-1:0] new_i,
  input  logic [NB-1:0]   mask_i,
  input  logic            mask_en_i,
  input  logic [CNTW-1:0] vl_i,
  input  logic [CNTW-1:0] vstart_i,
  input  logic [1:0]      sew_i,
  output logic [1:0]      policy_o,
  output logic            vill_o,
  output logic            result_valid_o,
  output logic [VLEN-1:0] result_o
);
  import vmerge_pkg::*;

  logic            tail_agn, mask_agn;
  logic [VLEN-1:0] merged;

  vmerge_policy_reg u_pol (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .pol_i     (cfg_policy_i),
    .pol_o     (policy_o),
    .vill_o    (vill_o),
    .tail_agn_o(tail_agn),
    .mask_agn_o(mask_agn)
  );

  for (genvar b = 0; b < NB; b++) begin : g_byte
    act_e act;

    vmerge_byte_class #(
      .NB(NB), .IDXW(IDXW), .CNTW(CNTW), .BYTE_IDX(b)
    ) u_cls (
      .sew_i     (sew_i),
      .vl_i      (vl_i),
      .vstart_i  (vstart_i),
      .mask_i    (mask_i),
      .mask_en_i (mask_en_i),
      .tail_agn_i(tail_agn),
      .mask_agn_i(mask_agn),
      .fill_i    (fill_ones_i),
      .vill_i    (vill_o),
      .act_o     (act)
    );

    vmerge_byte_mux u_mux (
      .act_i (act),
      .old_i (old_i[8*b +: 8]),
      .new_i (new_i[8*b +: 8]),
      .byte_o(merged[8*b +: 8])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_valid_o <= 1'b0;
      result_o       <= '0;
    end else begin
      result_valid_o <= valid_i;
      if (valid_i) result_o <= merged;
    end
  end
endmodule

// File: rtl/vmerge_wb_chk.sv
module vmerge_wb_chk #(
  parameter int VLEN = 128,
  parameter int NB   = VLEN / 8,
  parameter int CNTW = $clog2(NB) + 1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cfg_we_i,
  input logic [1:0]      cfg_policy_i,
  input logic            fill_ones_i,
  input logic            valid_i,
  input logic [VLEN-1:0] old_i,
  input logic [VLEN-1:0] new_i,
  input logic [CNTW-1:0] vstart_i,
  input logic [1:0]      policy_o,
  input logic            vill_o,
  input logic            result_valid_o,
  input logic [VLEN-1:0] result_o
);
  function automatic logic from_old_or_new(input logic [VLEN-1:0] r,
                                           input logic [VLEN-1:0] o,
                                           input logic [VLEN-1:0] n);
    logic ok;
    ok = 1'b1;
    for (int b = 0; b < NB; b++)
      if (r[8*b +: 8] != o[8*b +: 8] && r[8*b +: 8] != n[8*b +: 8]) ok = 1'b0;
    return ok;
  endfunction

  assert_policy_readback_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cfg_we_i) |-> policy_o == $past(cfg_policy_i));

  assert_vill_passes_old_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i) && $past(vill_o) |-> result_o == $past(old_i));

  assert_no_fill_no_ones_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i) && !$past(fill_ones_i) |->
      from_old_or_new(result_o, $past(old_i), $past(new_i)));

  assert_prestart_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i) && $past(vstart_i) != '0 |-> result_o[7:0] == $past(old_i[7:0]));

  assert_valid_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o == $past(valid_i));
endmodule

bind vmerge_wb vmerge_wb_chk #(.VLEN(VLEN)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_we_i      (cfg_we_i),
  .cfg_policy_i  (cfg_policy_i),
  .fill_ones_i   (fill_ones_i),
  .valid_i       (valid_i),
  .old_i         (old_i),
  .new_i         (new_i),
  .vstart_i      (vstart_i),
  .policy_o      (policy_o),
  .vill_o        (vill_o),
  .result_valid_o(result_valid_o),
  .result_o      (result_o)
);

// File: tb/vmerge_wb_tb_top.sv
module vmerge_wb_tb_top;
  localparam int VLEN = 128;
  localparam int NB   = VLEN / 8;
  localparam int CNTW = $clog2(NB) + 1;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            cfg_we_i = 1'b0;
  logic [1:0]      cfg_policy_i = '0;
  logic            fill_ones_i = 1'b0;
  logic            valid_i = 1'b0;
  logic [VLEN-1:0] old_i = '0;
  logic [VLEN-1:0] new_i = '0;
  logic [NB-1:0]   mask_i = '0;
  logic            mask_en_i = 1'b0;
  logic [CNTW-1:0] vl_i = '0;
  logic [CNTW-1:0] vstart_i = '0;
  logic [1:0]      sew_i = '0;
  logic [1:0]      policy_o;
  logic            vill_o;
  logic            result_valid_o;
  logic [VLEN-1:0] result_o;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [VLEN-1:0] OLD_A = {4{32'hA5C3_0F1E}};
  localparam logic [VLEN-1:0] NEW_A = 128'h0123_4567_89AB_CDEF_1357_9BDF_2468_ACE0;

  always #4 clk_i = ~clk_i;

  vmerge_wb #(.VLEN(VLEN)) dut_i (.*);

  task automatic check(input string req, input logic [VLEN-1:0] act,
                       input logic [VLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [VLEN-1:0] model(
      input logic [VLEN-1:0] o, input logic [VLEN-1:0] n, input logic [NB-1:0] m,
      input logic men, input int vl, input int vs, input int sew,
      input logic [1:0] pol, input logic fill);
    logic [VLEN-1:0] r;
    int w, ne;
    r = o;
    if (pol == 2'b01) return o;
    w  = 1 << sew;
    ne = NB / w;
    for (int e = 0; e < ne; e++) begin
      for (int k = 0; k < w; k++) begin
        int b;
        b = e * w + k;
        if (e < vs)              r[8*b +: 8] = o[8*b +: 8];
        else if (e >= vl)        r[8*b +: 8] = (pol[1] && fill) ? 8'hFF : o[8*b +: 8];
        else if (men && !m[e])   r[8*b +: 8] = (pol[0] && fill) ? 8'hFF : o[8*b +: 8];
        else                     r[8*b +: 8] = n[8*b +: 8];
      end
    end
    return r;
  endfunction

  task automatic set_policy(input logic [1:0] p);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_policy_i = p;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  // drive one merge and check it against the model
  task automatic merge(input string req, input logic [VLEN-1:0] o,
                       input logic [VLEN-1:0] n, input logic [NB-1:0] m,
                       input logic men, input int vl, input int vs, input int sew,
                       input logic fill);
    logic [VLEN-1:0] exp;
    @(negedge clk_i);
    old_i = o; new_i = n; mask_i = m; mask_en_i = men;
    vl_i = CNTW'(vl); vstart_i = CNTW'(vs); sew_i = 2'(sew); fill_ones_i = fill;
    valid_i = 1'b1;
    exp = model(o, n, m, men, vl, vs, sew, policy_o, fill);
    @(negedge clk_i);
    valid_i = 1'b0;
    check({req, " valid"}, VLEN'(result_valid_o), VLEN'(1));
    check(req, result_o, exp);
  endtask

  task automatic t_reset();
    check("R1 result", result_o, '0);
    check("R1 valid", VLEN'(result_valid_o), '0);
    check("R1 policy", VLEN'(policy_o), '0);
    check("R1 vill", VLEN'(vill_o), '0);
  endtask

  task automatic t_policy_rw();
    for (int p = 3; p >= 0; p--) begin
      set_policy(2'(p));
      check("R2 readback", VLEN'(policy_o), VLEN'(p));
      check("R3 vill flag", VLEN'(vill_o), VLEN'(p == 1));
    end
  endtask

  task automatic t_illegal();
    set_policy(2'b01);
    merge("R3 illegal passes old", OLD_A, NEW_A, 16'h00FF, 1'b1, 5, 0, 0, 1'b1);
    check("R3 explicit old", result_o, OLD_A);
  endtask

  task automatic t_active();
    set_policy(2'b00);
    merge("R4 all active", OLD_A, NEW_A, '0, 1'b0, 16, 0, 0, 1'b1);
    check("R4 explicit new", result_o, NEW_A);
    merge("R4 mask set active", OLD_A, NEW_A, 16'hFFFF, 1'b1, 16, 0, 0, 1'b0);
  endtask

  task automatic t_tail();
    set_policy(2'b00);
    merge("R5 tail undisturbed", OLD_A, NEW_A, '0, 1'b0, 5, 0, 1, 1'b1);
    set_policy(2'b10);
    merge("R6 tail agnostic ones", OLD_A, NEW_A, '0, 1'b0, 5, 0, 1, 1'b1);
    check("R6 top bytes ones", VLEN'(result_o[127:80]), VLEN'({48{1'b1}}));
    merge("R6 tail agnostic kept", OLD_A, NEW_A, '0, 1'b0, 5, 0, 1, 1'b0);
    merge("R6 vl zero all tail", OLD_A, NEW_A, '0, 1'b0, 0, 0, 0, 1'b1);
    check("R6 vl zero explicit", result_o, '1);
  endtask

  task automatic t_mask();
    set_policy(2'b10);
    merge("R7 masked undisturbed", OLD_A, NEW_A, 16'hA5C3, 1'b1, 12, 0, 0, 1'b1);
    set_policy(2'b11);
    merge("R7 masked agnostic ones", OLD_A, NEW_A, 16'hA5C3, 1'b1, 12, 0, 0, 1'b1);
    check("R7 elem2 masked ones", VLEN'(result_o[23:16]), VLEN'(8'hFF));
    merge("R7 masked agnostic kept", OLD_A, NEW_A, 16'hA5C3, 1'b1, 12, 0, 0, 1'b0);
  endtask

  task automatic t_vstart();
    set_policy(2'b11);
    merge("R8 prestart kept", OLD_A, NEW_A, 16'h0F0F, 1'b1, 10, 3, 0, 1'b1);
    check("R8 bytes0-2 old", VLEN'(result_o[23:0]), VLEN'(OLD_A[23:0]));
    merge("R8 vstart past vl", OLD_A, NEW_A, '0, 1'b0, 4, 6, 0, 1'b1);
  endtask

  task automatic t_sew();
    set_policy(2'b11);
    for (int s = 0; s < 4; s++)
      merge($sformatf("R9 sew code %0d", s), OLD_A, NEW_A, 16'b1011, 1'b1, 3, 1, s, 1'b1);
    merge("R9 vl over vlmax sew3", OLD_A, NEW_A, 16'b10, 1'b1, 9, 0, 3, 1'b1);
  endtask

  task automatic t_latency();
    @(negedge clk_i);
    check("R10 idle valid low", VLEN'(result_valid_o), '0);
    merge("R10 back to idle", OLD_A, NEW_A, '0, 1'b0, 7, 0, 0, 1'b1);
    @(negedge clk_i);
    check("R10 one cycle only", VLEN'(result_valid_o), '0);
  endtask

  initial begin
    fork
      begin
        #20 rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_policy_rw();
        t_illegal();
        t_active();
        t_tail();
        t_mask();
        t_vstart();
        t_sew();
        t_latency();
      end
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule